// File: doc/BRIEF.md
# Retention Self-Test Sequencer

This controller runs an at-speed retention test on a small dynamic two-port memory array (64 words of 32 bits by default). Before a run, software or a scan chain shifts a configuration word into the controller serially. The word selects a data pattern, a disturb share and an idle duration. A start strobe then launches a fixed sequence:

- fill every row with the pattern;
- wait the programmed number of idle cycles;
- read every row back;
- write, for each row, the bitwise difference between the read data and the pattern into a result memory of the same size.

The result is a per-bit fail map.

During the idle wait, the controller can spend an even, programmable share of the cycles driving the write bit lines to the inverse of the stored data. No row is selected during these cycles, so they imitate the leakage stress that writes to other rows in the same columns would cause. At all other times when no write is under way, the bit-line control asks for the neutral mid-level bias. The array, its sensing and the bias generator itself are outside this block.

Top module: `ret_bist_ctrl`

## Requirements
- R1: After synchronous reset `busy`, `done` and `any_fail` are low, `bl_mode` is bias (2'b00), and the configuration is pattern code 1, disturb share 0 and duration 0.
- R2: While `cfg_shift_en` is high and the controller is not busy, `cfg_shift_in` shifts into a 33-bit configuration word, most significant bit first. Bits [32:31] are the pattern code, bits [30:24] the disturb percentage and bits [23:0] the idle duration in cycles. Shifting while busy has no effect.
- R3: Pattern code 0 gives 32'h0000_0000, code 1 gives 32'hFFFF_FFFF, code 2 gives 32'h5555_5555 and code 3 gives 32'hAAAA_AAAA.
- R4: The cycle after `start` is accepted, the controller writes rows 0 to 63 in 64 consecutive cycles with the pattern. During each of these cycles `bl_mode` is drive (2'b01) and `bl_data` equals the write data.
- R5: Exactly the configured number of idle cycles separates the last write cycle from the first read cycle. A duration of 0 makes the read of row 0 follow the write of row 63 directly. No array access happens during the idle cycles.
- R6: Over an idle wait of D cycles with share P, exactly floor(D*min(P,100)/100) cycles are disturb cycles, spread evenly. In each disturb cycle `bl_mode` is 2'b10 and `bl_data` is the inverse of the pattern, with no array write.
- R7: `bl_mode` is bias (2'b00) in every cycle that is neither a write cycle nor a disturb cycle.
- R8: The controller reads rows 0 to 63 in 64 consecutive cycles. Each row's result is written one cycle after its read is issued, at the same row address, with data equal to the read data XOR the pattern.
- R9: `busy` is high from the cycle after an accepted start until the last result write. `done` is high for exactly one cycle, the cycle after the last result write.
- R10: `any_fail` is the sticky OR of all result bits of the current run and is cleared when a start is accepted.
- R11: A `start` pulse while busy is ignored: the run in progress carries on unchanged and produces one set of 64 results and one `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_shift_en | input | 1 | Configuration shift enable |
| cfg_shift_in | input | 1 | Configuration serial data |
| start | input | 1 | Run request strobe |
| arr_we | output | 1 | Array write enable |
| arr_waddr | output | 6 | Array write row |
| arr_wdata | output | 32 | Array write data |
| arr_re | output | 1 | Array read enable |
| arr_raddr | output | 6 | Array read row |
| arr_rdata | input | 32 | Array read data, valid one cycle after `arr_re` |
| bl_mode | output | 2 | Write bit-line mode: 0 bias, 1 drive, 2 disturb |
| bl_data | output | 32 | Value for the write bit lines in drive or disturb mode |
| res_we | output | 1 | Result memory write enable |
| res_addr | output | 6 | Result memory row |
| res_wdata | output | 32 | Per-bit fail map for the row |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| any_fail | output | 1 | Sticky OR of all fail bits of the run |

## Verification
The bench targets a zero idle duration, a share above 100, a 5% share over 200 cycles and a 50% share over an even count. An off-by-one in the hold counter shows up as a wrong write-to-read gap. A broken wrap in the accumulator shows up as a wrong disturb count or wrong disturb data. It injects bit flips on the first and last rows: a misaligned compare stage would attribute them to the wrong row or miss row 63. It also pulses start and shifts a new configuration in the middle of a run. A design that accepts either would restart the run or change the pattern seen by the following run. Finally, it runs a clean pass after a failing one, to catch an `any_fail` that is never cleared.

// File: rtl/ret_bist_pkg.sv
package ret_bist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_HOLD,
        ST_READ,
        ST_FLUSH
    } bist_state_e;

    typedef enum logic [1:0] {
        BL_BIAS    = 2'd0,
        BL_DRIVE   = 2'd1,
        BL_DISTURB = 2'd2
    } bl_mode_e;

endpackage

// File: rtl/ret_bist_cfg.sv
module ret_bist_cfg #(
    parameter int PCT_W = 7,
    parameter int DUR_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             shift_in,
    input  logic             lock,
    output logic [1:0]       pat_sel,
    output logic [PCT_W-1:0] pct,
    output logic [DUR_W-1:0] dur
);
    localparam int CFG_W = 2 + PCT_W + DUR_W;
    localparam logic [CFG_W-1:0] CFG_RST = {2'b01, {PCT_W{1'b0}}, {DUR_W{1'b0}}};

    typedef struct packed {
        logic [CFG_W-1:0] word;
    } cfg_regs_t;

    cfg_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (shift_en && !lock) begin
            r_d.word = {r_q.word[CFG_W-2:0], shift_in};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.word <= CFG_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign pat_sel = r_q.word[CFG_W-1 -: 2];
    assign pct     = r_q.word[DUR_W +: PCT_W];
    assign dur     = r_q.word[DUR_W-1:0];
endmodule

// File: rtl/ret_bist_pat.sv
module ret_bist_pat #(
    parameter int WIDTH = 32
) (
    input  logic [1:0]       sel,
    output logic [WIDTH-1:0] pattern
);
    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
        localparam bit EVEN = ((gi % 2) == 0);
        assign pattern[gi] = sel[1] ? (sel[0] ? !EVEN : EVEN) : sel[0];
    end
endmodule

// File: rtl/ret_bist_pace.sv
module ret_bist_pace #(
    parameter int PCT_W      = 7,
    parameter int DUR_W      = 24,
    parameter int SHARE_FULL = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             load,
    input  logic             hold_en,
    input  logic [PCT_W-1:0] pct,
    input  logic [DUR_W-1:0] dur,
    output logic             disturb,
    output logic             hold_last
);
    localparam logic [PCT_W:0] FULL = (PCT_W + 1)'(SHARE_FULL);

    typedef struct packed {
        logic [PCT_W:0]   acc;
        logic [DUR_W-1:0] cnt;
    } pace_regs_t;

    pace_regs_t r_d, r_q;
    logic [PCT_W:0] pct_x, pct_eff, sum;

    always_comb begin
        pct_x   = {1'b0, pct};
        pct_eff = (pct_x > FULL) ? FULL : pct_x;
        sum     = r_q.acc + pct_eff;
        disturb = hold_en && (sum >= FULL);
        hold_last = (r_q.cnt == DUR_W'(1));

        r_d = r_q;
        if (clear) begin
            r_d.acc = '0;
        end else if (hold_en) begin
            r_d.acc = disturb ? (sum - FULL) : sum;
        end

        if (load) begin
            r_d.cnt = dur;
        end else if (hold_en) begin
            r_d.cnt = r_q.cnt - DUR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/ret_bist_cmp.sv
module ret_bist_cmp #(
    parameter int WIDTH = 32,
    parameter int AW    = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             issue,
    input  logic [AW-1:0]    issue_addr,
    input  logic [WIDTH-1:0] expect_word,
    input  logic [WIDTH-1:0] rdata,
    output logic             res_we,
    output logic [AW-1:0]    res_addr,
    output logic [WIDTH-1:0] res_wdata,
    output logic             any_fail
);
    typedef struct packed {
        logic          pend;
        logic [AW-1:0] addr;
        logic          fail;
    } cmp_regs_t;

    cmp_regs_t r_d, r_q;

    always_comb begin
        res_we    = r_q.pend;
        res_addr  = r_q.addr;
        res_wdata = rdata ^ expect_word;

        r_d      = r_q;
        r_d.pend = issue;
        if (issue) begin
            r_d.addr = issue_addr;
        end
        if (clear) begin
            r_d.fail = 1'b0;
        end else if (r_q.pend && (|res_wdata)) begin
            r_d.fail = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign any_fail = r_q.fail;
endmodule

// File: rtl/ret_bist_ctrl.sv
module ret_bist_ctrl #(
    parameter int ROWS  = 64,
    parameter int WIDTH = 32,
    parameter int PCT_W = 7,
    parameter int DUR_W = 24
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_shift_en,
    input  logic                     cfg_shift_in,
    input  logic                     start,
    output logic                     arr_we,
    output logic [$clog2(ROWS)-1:0]  arr_waddr,
    output logic [WIDTH-1:0]         arr_wdata,
    output logic                     arr_re,
    output logic [$clog2(ROWS)-1:0]  arr_raddr,
    input  logic [WIDTH-1:0]         arr_rdata,
    output logic [1:0]               bl_mode,
    output logic [WIDTH-1:0]         bl_data,
    output logic                     res_we,
    output logic [$clog2(ROWS)-1:0]  res_addr,
    output logic [WIDTH-1:0]         res_wdata,
    output logic                     busy,
    output logic                     done,
    output logic                     any_fail
);
    import ret_bist_pkg::*;

    localparam int AW = $clog2(ROWS);
    localparam logic [AW-1:0] LAST_ROW = AW'(ROWS - 1);

    typedef struct packed {
        bist_state_e   state;
        logic [AW-1:0] row;
        logic          done;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;

    logic [1:0]       pat_sel;
    logic [PCT_W-1:0] pct;
    logic [DUR_W-1:0] dur;
    logic [WIDTH-1:0] pattern;
    logic             accept, load_hold, in_hold, disturb, hold_last;

    ret_bist_cfg #(.PCT_W(PCT_W), .DUR_W(DUR_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .shift_en (cfg_shift_en),
        .shift_in (cfg_shift_in),
        .lock     (busy),
        .pat_sel  (pat_sel),
        .pct      (pct),
        .dur      (dur)
    );

    ret_bist_pat #(.WIDTH(WIDTH)) u_pat (
        .sel     (pat_sel),
        .pattern (pattern)
    );

    ret_bist_pace #(.PCT_W(PCT_W), .DUR_W(DUR_W), .SHARE_FULL(100)) u_pace (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .load      (load_hold),
        .hold_en   (in_hold),
        .pct       (pct),
        .dur       (dur),
        .disturb   (disturb),
        .hold_last (hold_last)
    );

    ret_bist_cmp #(.WIDTH(WIDTH), .AW(AW)) u_cmp (
        .clk         (clk),
        .rst         (rst),
        .clear       (accept),
        .issue       (arr_re),
        .issue_addr  (arr_raddr),
        .expect_word (pattern),
        .rdata       (arr_rdata),
        .res_we      (res_we),
        .res_addr    (res_addr),
        .res_wdata   (res_wdata),
        .any_fail    (any_fail)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        accept    = 1'b0;
        load_hold = 1'b0;
        in_hold   = (r_q.state == ST_HOLD);

        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    accept    = 1'b1;
                    r_d.state = ST_WRITE;
                    r_d.row   = '0;
                end
            end
            ST_WRITE: begin
                if (r_q.row == LAST_ROW) begin
                    r_d.row = '0;
                    if (dur == '0) begin
                        r_d.state = ST_READ;
                    end else begin
                        load_hold = 1'b1;
                        r_d.state = ST_HOLD;
                    end
                end else begin
                    r_d.row = r_q.row + AW'(1);
                end
            end
            ST_HOLD: begin
                if (hold_last) begin
                    r_d.state = ST_READ;
                    r_d.row   = '0;
                end
            end
            ST_READ: begin
                if (r_q.row == LAST_ROW) begin
                    r_d.state = ST_FLUSH;
                end else begin
                    r_d.row = r_q.row + AW'(1);
                end
            end
            ST_FLUSH: begin
                r_d.state = ST_IDLE;
                r_d.done  = 1'b1;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state <= ST_IDLE;
            r_q.row   <= '0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        arr_we    = (r_q.state == ST_WRITE);
        arr_waddr = r_q.row;
        arr_wdata = pattern;
        arr_re    = (r_q.state == ST_READ);
        arr_raddr = r_q.row;
        busy      = (r_q.state != ST_IDLE);
        done      = r_q.done;
        if (arr_we) begin
            bl_mode = BL_DRIVE;
            bl_data = pattern;
        end else if (disturb) begin
            bl_mode = BL_DISTURB;
            bl_data = ~pattern;
        end else begin
            bl_mode = BL_BIAS;
            bl_data = '0;
        end
    end
endmodule

module ret_bist_ctrl_chk #(
    parameter int AW    = 6,
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             arr_we,
    input logic [AW-1:0]    arr_waddr,
    input logic [WIDTH-1:0] arr_wdata,
    input logic             arr_re,
    input logic [AW-1:0]    arr_raddr,
    input logic [1:0]       bl_mode,
    input logic [WIDTH-1:0] bl_data,
    input logic             res_we,
    input logic [AW-1:0]    res_addr,
    input logic             busy,
    input logic             done,
    input logic             any_fail
);
    // R7
    bias_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> bl_mode == 2'd0);

    // R4
    write_drives_lines_chk: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> (bl_mode == 2'd1 && bl_data == arr_wdata && !arr_re));

    // R4
    write_rows_ascend_chk: assert property (@(posedge clk) disable iff (rst)
        (arr_we && $past(arr_we)) |-> arr_waddr == $past(arr_waddr) + AW'(1));

    // R6
    disturb_no_access_chk: assert property (@(posedge clk) disable iff (rst)
        bl_mode == 2'd2 |-> (!arr_we && !arr_re));

    // R8
    result_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
        arr_re |=> (res_we && res_addr == $past(arr_raddr)));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(res_we)));

    // R10
    fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && $past(any_fail)) |-> any_fail);

    // R11
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !done && !res_we) |=> busy);
endmodule

bind ret_bist_ctrl ret_bist_ctrl_chk #(.AW($clog2(ROWS)), .WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .arr_we    (arr_we),
    .arr_waddr (arr_waddr),
    .arr_wdata (arr_wdata),
    .arr_re    (arr_re),
    .arr_raddr (arr_raddr),
    .bl_mode   (bl_mode),
    .bl_data   (bl_data),
    .res_we    (res_we),
    .res_addr  (res_addr),
    .busy      (busy),
    .done      (done),
    .any_fail  (any_fail)
);

// File: tb/ret_bist_ctrl_tb.sv
module ret_bist_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS = 64;
    localparam int W    = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_shift_en = 1'b0;
    logic cfg_shift_in = 1'b0;
    logic start = 1'b0;
    logic arr_we, arr_re, res_we, busy, done, any_fail;
    logic [5:0] arr_waddr, arr_raddr, res_addr;
    logic [W-1:0] arr_wdata, arr_rdata, bl_data, res_wdata;
    logic [1:0] bl_mode;

    always #(CLK_PERIOD/2) clk = ~clk;

    ret_bist_ctrl u_dut (
        .clk(clk), .rst(rst), .cfg_shift_en(cfg_shift_en), .cfg_shift_in(cfg_shift_in),
        .start(start), .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
        .arr_re(arr_re), .arr_raddr(arr_raddr), .arr_rdata(arr_rdata),
        .bl_mode(bl_mode), .bl_data(bl_data), .res_we(res_we), .res_addr(res_addr),
        .res_wdata(res_wdata), .busy(busy), .done(done), .any_fail(any_fail)
    );

    // behavioural array with injectable read faults
    logic [W-1:0] mem  [ROWS];
    logic [W-1:0] flip [ROWS];
    logic [W-1:0] rdata_q = '0;
    assign arr_rdata = rdata_q;
    always @(posedge clk) begin
        if (arr_we) mem[arr_waddr] <= arr_wdata;
        if (arr_re) rdata_q <= mem[arr_raddr] ^ flip[arr_raddr];
    end

    int checks = 0;
    int fails  = 0;
    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // scoreboard
    int           sb_addr[$];
    logic [W-1:0] sb_data[$];
    logic [W-1:0] cur_pat;
    int cyc = 0, wr_cnt = 0, wr_bad = 0, rd_cnt = 0, dist_cnt = 0, dist_bad = 0;
    int res_cnt = 0, done_cnt = 0, last_wr = 0, first_rd = 0, last_res = 0, done_cyc = 0;
    int bias_bad = 0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (arr_we) begin
                if (arr_wdata !== cur_pat || arr_waddr !== 6'(wr_cnt) ||
                    bl_mode !== 2'd1 || bl_data !== cur_pat) wr_bad++;
                wr_cnt++;
                last_wr = cyc;
            end
            if (arr_re) begin
                if (rd_cnt == 0) first_rd = cyc;
                if (arr_raddr !== 6'(rd_cnt)) wr_bad++;
                rd_cnt++;
            end
            if (bl_mode == 2'd2) begin
                dist_cnt++;
                if (bl_data !== ~cur_pat || arr_we || arr_re) dist_bad++;
            end else if (!arr_we && bl_mode !== 2'd0) begin
                bias_bad++;
            end
            if (res_we) begin
                res_cnt++;
                last_res = cyc;
                if (sb_addr.size() == 0) begin
                    check(1'b0, "R8", "unexpected result write", res_addr, 0);
                end else begin
                    int ea;
                    logic [W-1:0] ed;
                    ea = sb_addr.pop_front();
                    ed = sb_data.pop_front();
                    check(res_addr == 6'(ea) && res_wdata == ed, "R8", "result row/data",
                          {res_addr, res_wdata}, {6'(ea), ed});
                end
            end
            if (done) begin
                done_cnt++;
                done_cyc = cyc;
            end
        end
    end

    task automatic shift_cfg(input logic [1:0] pat, input int pct, input int dur);
        logic [32:0] w;
        w = {pat, 7'(pct), 24'(dur)};
        for (int i = 32; i >= 0; i--) begin
            cfg_shift_en = 1'b1;
            cfg_shift_in = w[i];
            @(posedge clk); #1;
        end
        cfg_shift_en = 1'b0;
    endtask

    task automatic run_test(input string tag, input logic [W-1:0] pat, input int pct,
                            input int dur, input bit poke, input bit exp_fail);
        int exp_dist, lim;
        exp_dist = dur * ((pct > 100) ? 100 : pct) / 100;
        cur_pat = pat;
        wr_cnt = 0; wr_bad = 0; rd_cnt = 0; dist_cnt = 0; dist_bad = 0;
        res_cnt = 0; done_cnt = 0; bias_bad = 0;
        for (int r = 0; r < ROWS; r++) begin
            sb_addr.push_back(r);
            sb_data.push_back(flip[r]);
        end
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        if (poke) begin
            repeat (5) @(posedge clk);
            #1 start = 1'b1;           // R11: start while busy
            @(posedge clk); #1;
            start = 1'b0;
            shift_cfg(2'd3, 0, 0);     // R2: shift while busy
        end
        lim = 0;
        while (done_cnt == 0 && lim < dur + 1000) begin
            @(posedge clk); #1;
            lim++;
        end
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        $display("%s: writes=%0d reads=%0d disturb=%0d", tag, wr_cnt, rd_cnt, dist_cnt);
        check(wr_cnt == ROWS && wr_bad == 0, "R4", "write phase rows/data", wr_cnt, ROWS);
        check(wr_bad == 0, "R3", "pattern word errors", wr_bad, 0);
        check(first_rd - last_wr - 1 == dur, "R5", "idle gap", first_rd - last_wr - 1, dur);
        check(dist_cnt == exp_dist, "R6", "disturb count", dist_cnt, exp_dist);
        check(dist_bad == 0, "R6", "disturb data", dist_bad, 0);
        check(bias_bad == 0, "R7", "bias elsewhere", bias_bad, 0);
        check(rd_cnt == ROWS && res_cnt == ROWS && sb_addr.size() == 0, "R11",
              "one set of results", res_cnt, ROWS);
        check(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
        check(done_cyc == last_res + 1, "R9", "done timing", done_cyc, last_res + 1);
        check(!busy, "R9", "busy after done", busy, 0);
        check(any_fail == exp_fail, "R10", "any_fail", any_fail, exp_fail);
        sb_addr.delete();
        sb_data.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int r = 0; r < ROWS; r++) flip[r] = '0;
        cur_pat = '1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk); #1;
        // R1 reset state
        check(!busy && !done && !any_fail, "R1", "flags after reset",
              {busy, done, any_fail}, 0);
        check(bl_mode == 2'd0, "R1", "bias after reset", bl_mode, 0);
        // R1 default configuration: all-1, no idle, no disturb
        run_test("default", 32'hFFFF_FFFF, 0, 0, 1'b0, 1'b0);

        // R2 R3 code 0, 50% over 10 cycles, faults on first and last rows
        flip[0]  = 32'h0000_0100;
        flip[63] = 32'h8000_0001;
        @(posedge clk); #1;
        shift_cfg(2'd0, 50, 10);
        run_test("zeros", 32'h0000_0000, 50, 10, 1'b0, 1'b1);

        // R11 R2 code 2, 5% over 200, pokes while busy, one fault
        flip[0] = '0; flip[63] = '0; flip[17] = 32'h0000_4000;
        shift_cfg(2'd2, 5, 200);
        run_test("stripes", 32'h5555_5555, 5, 200, 1'b1, 1'b1);
        // configuration must be unchanged by the mid-run shift (R2); clean run clears any_fail (R10)
        flip[17] = '0;
        run_test("stripes_again", 32'h5555_5555, 5, 200, 1'b0, 1'b0);

        // R6 share above 100 clamps
        shift_cfg(2'd3, 120, 7);
        run_test("clamp", 32'hAAAA_AAAA, 120, 7, 1'b0, 1'b0);

        // R5 single idle cycle, full disturb
        shift_cfg(2'd1, 100, 1);
        run_test("one", 32'hFFFF_FFFF, 100, 1, 1'b0, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule